// File: doc/BRIEF.md
# Masked-Access GPIO Port

This block is an eight-pin general-purpose I/O port that sits on a simple memory-mapped register bus with byte-wide data. Each pin can be made an input or an output through a direction register. Output values are held in an output register, and input pins are brought into the clock domain through a two-flop synchronizer before they can be read.

The data register takes up a whole window of addresses. Word-address bits [9:2] of every data access act as a per-pin mask. A write changes only the pins selected by the mask. A read returns zero in every position the mask leaves out. Software can therefore set or clear a single pin in one bus write, with no read-modify-write sequence. To reach pin n alone, software uses byte offset 1 << (n+2).

Interrupt detection lives in a neighbouring block. This port only stores that block's configuration, presents its raw status to software, and passes software's clear requests on to it as a one-cycle pulse. The bus uses one access cycle per transfer: `bus_sel` with `bus_wr` high is a write, and `bus_sel` with `bus_wr` low is a read. A read returns its data one cycle after it is accepted.

Top module: `maskgpio`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, `irq_sense`, `irq_both`, `irq_event`, `irq_enable`, `irq_clear` and `bus_rdata` are all zero. Every pin starts as an input.
- R2: The direction register sits at byte offset 0x400 and can be read and written. Bit n set to 1 makes pin n an output. `pin_oe` shows the register from the cycle after the write.
- R3: A write to the data window (byte offsets 0x000 to 0x3FC) updates `pin_out[n]` only where address bit [n+2] is 1. All other output bits keep their value.
- R4: A data write leaves the stored output value of a pin that is an input at that moment unchanged. The pin still shows its old value after it is later switched to output.
- R5: A data read returns 0 in every bit position whose address mask bit [n+2] is 0. Offset 0x3FC reads all eight pins, and offset 0x000 reads 0.
- R6: A data read returns the synchronized pin input for input pins and the output register value for output pins.
- R7: Input pins pass through two flops. A change on `pin_in` that is driven before rising edge A is not seen by a read accepted at edge A+1, and is seen by a read accepted at edge A+2.
- R8: The interrupt configuration registers can be read and written: sense at 0x404, both-edges at 0x408, event at 0x40C and enable at 0x410. They drive `irq_sense`, `irq_both`, `irq_event` and `irq_enable`.
- R9: Offset 0x414 reads `irq_raw`, and offset 0x418 reads `irq_raw & irq_enable`. Writes to these two offsets change nothing.
- R10: A write to 0x41C drives the written byte on `irq_clear` for exactly the next cycle, after which `irq_clear` returns to 0. Reads of 0x41C return 0.
- R11: Offsets from 0x420 to 0xFFC are unmapped. Reads there return 0, and writes there change no output.
- R12: `bus_rdata` is updated only at the rising edge that accepts a read. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe, one cycle per transfer |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Word address, byte-address bits [11:2] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid from the cycle after the read |
| pin_in | input | 8 | Pin input levels, asynchronous |
| pin_out | output | 8 | Output value for each pin |
| pin_oe | output | 8 | Output enable for each pin |
| irq_raw | input | 8 | Raw status from the interrupt detector |
| irq_sense | output | 8 | Level (1) or edge (0) selection for each pin |
| irq_both | output | 8 | Both-edges selection for each pin |
| irq_event | output | 8 | Polarity selection for each pin |
| irq_enable | output | 8 | Interrupt enable for each pin |
| irq_clear | output | 8 | One-cycle clear pulse for each pin |

## Verification
The bound checker watches every cycle for the things that can be seen at the ports:
- a data write never touches output bits outside its address mask, and never touches input pins;
- `pin_out` and `pin_oe` move only on writes to their own registers;
- masked reads never return bits outside the mask;
- unmapped reads return zero;
- `bus_rdata` moves only on reads;
- a clear pulse always follows a clear write.

Some properties need a history of writes and are shown only by the bench scenarios:
- that a write to an input pin is lost, which shows once the pin is switched to output;
- the exact two-edge latency of the input synchronizer;
- the mixing of input and output sources in a data read;
- the masked-status combination.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;

  // Control page slot index: word-address bits [4:2] inside page 1.
  // The order fixes the byte offsets 0x400 to 0x41C that software relies on.
  typedef enum logic [2:0] {
    SLOT_DIR    = 3'd0,
    SLOT_SENSE  = 3'd1,
    SLOT_BOTH   = 3'd2,
    SLOT_EVENT  = 3'd3,
    SLOT_ENABLE = 3'd4,
    SLOT_RAW    = 3'd5,
    SLOT_MASKED = 3'd6,
    SLOT_CLEAR  = 3'd7
  } ctrl_slot_e;

  localparam int SLOT_BITS = 3;

  // Address pages above the mask field.
  localparam int PAGE_DATA = 0;
  localparam int PAGE_CTRL = 1;

endpackage

// File: rtl/maskgpio_rst_sync.sv
module maskgpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/maskgpio_in_sync.sv
module maskgpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] din,
  output logic [PINS-1:0] dout
);

  logic [STAGES-1:0][PINS-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q[0] <= '0;
    end else begin
      stage_q[0] <= din;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/maskgpio_regs.sv
module maskgpio_regs
  import maskgpio_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_sync,
  input  logic [PINS-1:0]   irq_raw,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   cfg_sense,
  output logic [PINS-1:0]   cfg_both,
  output logic [PINS-1:0]   cfg_event,
  output logic [PINS-1:0]   cfg_enable,
  output logic [PINS-1:0]   irq_clear
);

  localparam int PAGE_LO = PINS + 2;
  localparam int PAGE_W  = ADDR_W - PAGE_LO;

  // Address split: page selects data window or control page, lane is the mask
  logic [PAGE_W-1:0] page;
  logic [PINS-1:0]   lane;
  logic              hit_data;
  logic              hit_ctrl;
  ctrl_slot_e        slot;
  logic              wr_acc;
  logic              rd_acc;

  assign page     = bus_addr[ADDR_W-1:PAGE_LO];
  assign lane     = bus_addr[PAGE_LO-1:2];
  assign hit_data = (page == PAGE_W'(PAGE_DATA));
  assign hit_ctrl = (page == PAGE_W'(PAGE_CTRL)) && (lane[PINS-1:SLOT_BITS] == '0);
  assign slot     = ctrl_slot_e'(lane[SLOT_BITS-1:0]);
  assign wr_acc   = bus_sel && bus_wr;
  assign rd_acc   = bus_sel && !bus_wr;

  // State
  logic [PINS-1:0] dir_q,   dir_d;
  logic [PINS-1:0] out_q,   out_d;
  logic [PINS-1:0] sense_q, sense_d;
  logic [PINS-1:0] both_q,  both_d;
  logic [PINS-1:0] event_q, event_d;
  logic [PINS-1:0] en_q,    en_d;
  logic [PINS-1:0] clr_q,   clr_d;
  logic [PINS-1:0] rdata_q, rd_val;
  logic [PINS-1:0] data_view;

  // Per-pin output update: masked by address lane and by current direction
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      if (wr_acc && hit_data && lane[i] && dir_q[i]) begin
        out_d[i] = bus_wdata[i];
      end else begin
        out_d[i] = out_q[i];
      end
    end

    always_comb begin
      if (dir_q[i]) begin
        data_view[i] = out_q[i];
      end else begin
        data_view[i] = pin_sync[i];
      end
    end
  end

  // Control page write decode
  always_comb begin
    dir_d   = dir_q;
    sense_d = sense_q;
    both_d  = both_q;
    event_d = event_q;
    en_d    = en_q;
    clr_d   = '0;
    if (wr_acc && hit_ctrl) begin
      unique case (slot)
        SLOT_DIR:    dir_d   = bus_wdata;
        SLOT_SENSE:  sense_d = bus_wdata;
        SLOT_BOTH:   both_d  = bus_wdata;
        SLOT_EVENT:  event_d = bus_wdata;
        SLOT_ENABLE: en_d    = bus_wdata;
        SLOT_CLEAR:  clr_d   = bus_wdata;
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    if (hit_data) begin
      rd_val = data_view & lane;
    end else if (hit_ctrl) begin
      unique case (slot)
        SLOT_DIR:    rd_val = dir_q;
        SLOT_SENSE:  rd_val = sense_q;
        SLOT_BOTH:   rd_val = both_q;
        SLOT_EVENT:  rd_val = event_q;
        SLOT_ENABLE: rd_val = en_q;
        SLOT_RAW:    rd_val = irq_raw;
        SLOT_MASKED: rd_val = irq_raw & en_q;
        default:     rd_val = '0;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      en_q    <= '0;
      clr_q   <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      event_q <= event_d;
      en_q    <= en_d;
      clr_q   <= clr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_acc) begin
      rdata_q <= rd_val;
    end
  end

  assign bus_rdata  = rdata_q;
  assign pin_out    = out_q;
  assign pin_oe     = dir_q;
  assign cfg_sense  = sense_q;
  assign cfg_both   = both_q;
  assign cfg_event  = event_q;
  assign cfg_enable = en_q;
  assign irq_clear  = clr_q;

endmodule

// File: rtl/maskgpio.sv
module maskgpio #(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  input  logic [PINS-1:0]   irq_raw,
  output logic [PINS-1:0]   irq_sense,
  output logic [PINS-1:0]   irq_both,
  output logic [PINS-1:0]   irq_event,
  output logic [PINS-1:0]   irq_enable,
  output logic [PINS-1:0]   irq_clear
);

  logic            rst_n_int;
  logic [PINS-1:0] pin_sync;

  maskgpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  maskgpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  maskgpio_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_sync   (pin_sync),
    .irq_raw    (irq_raw),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cfg_sense  (irq_sense),
    .cfg_both   (irq_both),
    .cfg_event  (irq_event),
    .cfg_enable (irq_enable),
    .irq_clear  (irq_clear)
  );

endmodule

// File: rtl/maskgpio_chk.sv
module maskgpio_chk #(
  parameter int PINS   = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:2] bus_addr,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   irq_clear
);

  localparam int PAGE_LO = PINS + 2;
  localparam int PAGE_W  = ADDR_W - PAGE_LO;

  logic [PAGE_W-1:0] page;
  logic [PINS-1:0]   lane;
  logic data_wr, data_rd, dir_wr, clr_wr, any_rd, unmapped_rd;

  assign page        = bus_addr[ADDR_W-1:PAGE_LO];
  assign lane        = bus_addr[PAGE_LO-1:2];
  assign data_wr     = bus_sel && bus_wr && (page == '0);
  assign data_rd     = bus_sel && !bus_wr && (page == '0);
  assign dir_wr      = bus_sel && bus_wr && (page == PAGE_W'(1)) && (lane == '0);
  assign clr_wr      = bus_sel && bus_wr && (page == PAGE_W'(1)) && (lane == PINS'(7));
  assign any_rd      = bus_sel && !bus_wr;
  assign unmapped_rd = any_rd && (page > PAGE_W'(1) || (page == PAGE_W'(1) && lane > PINS'(7)));

  // R3
  data_mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_wr) |-> (((pin_out ^ $past(pin_out)) & ~$past(lane)) == '0));

  // R4
  input_pin_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_wr) |-> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr) |-> $stable(pin_out));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dir_wr) |-> $stable(pin_oe));

  // R5
  read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(data_rd) |-> ((bus_rdata & ~$past(lane)) == '0));

  // R10
  clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear != '0) |-> $past(clr_wr));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unmapped_rd) |-> (bus_rdata == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_rd) |-> $stable(bus_rdata));

endmodule

bind maskgpio maskgpio_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_clear (irq_clear)
);

// File: tb/maskgpio_tb.sv
module maskgpio_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hA5;
  logic [7:0] pin_out, pin_oe;
  logic [7:0] irq_raw = 8'h00;
  logic [7:0] irq_sense, irq_both, irq_event, irq_enable, irq_clear;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] q_exp[$];
  string      q_tag[$];
  logic       rd_fire = 1'b0;
  logic [7:0] last_rd = '0;

  always #10 clk = ~clk;

  maskgpio u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_raw(irq_raw),
    .irq_sense(irq_sense), .irq_both(irq_both), .irq_event(irq_event),
    .irq_enable(irq_enable), .irq_clear(irq_clear)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // Driver: issue a read, push expected result into the scoreboard
  task automatic rd(logic [9:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  // Monitor
  always @(posedge clk) rd_fire <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (q_exp.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read result actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        last_rd = e;
        chk(t, bus_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 cfg", irq_sense | irq_both | irq_event | irq_enable, 8'h00);
    chk("R1 irq_clear", irq_clear, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(10'h100, 8'h00, "R1 dir read");

    // R4 write while all pins are inputs: lost
    wr(10'h0FF, 8'hFF);
    chk("R4 pin_out after input write", pin_out, 8'h00);

    // R2 direction
    wr(10'h100, 8'h0F);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    chk("R4 stored value still 0", pin_out, 8'h00);
    rd(10'h100, 8'h0F, "R2 dir read");

    // R3 masked writes
    wr(10'h002, 8'hFF);
    chk("R3 single pin 1", pin_out, 8'h02);
    wr(10'h00C, 8'h04);
    chk("R3 mask 0C", pin_out, 8'h06);
    wr(10'h0FF, 8'h5A);
    chk("R3 full mask, outputs only", pin_out, 8'h0A);

    // R5 / R6 reads: out 0A on low nibble, pin_in A5 on high nibble
    rd(10'h0FF, 8'hAA, "R6 mixed source read");
    rd(10'h030, 8'h20, "R5 masked read 30");
    rd(10'h000, 8'h00, "R5 empty mask read");

    // R7 synchronizer latency
    @(negedge clk);
    bus_sel = 1'b0;
    pin_in = 8'h5A;
    rd(10'h0F0, 8'hA0, "R7 old value one edge after change");
    rd(10'h0F0, 8'h50, "R7 new value two edges after change");
    idle(1);

    // R8 configuration registers
    wr(10'h101, 8'h11);
    wr(10'h102, 8'h22);
    wr(10'h103, 8'h33);
    wr(10'h104, 8'h0F);
    chk("R8 sense", irq_sense, 8'h11);
    chk("R8 both", irq_both, 8'h22);
    chk("R8 event", irq_event, 8'h33);
    chk("R8 enable", irq_enable, 8'h0F);
    rd(10'h101, 8'h11, "R8 sense read");
    rd(10'h103, 8'h33, "R8 event read");

    // R9 status
    irq_raw = 8'h3C;
    rd(10'h105, 8'h3C, "R9 raw read");
    rd(10'h106, 8'h0C, "R9 masked read");
    wr(10'h105, 8'hFF);
    wr(10'h106, 8'hFF);
    chk("R9 enable unchanged", irq_enable, 8'h0F);
    rd(10'h105, 8'h3C, "R9 raw after write");

    // R10 clear pulse
    wr(10'h107, 8'h81);
    chk("R10 clear pulse", irq_clear, 8'h81);
    @(negedge clk);
    chk("R10 clear pulse ends", irq_clear, 8'h00);
    rd(10'h107, 8'h00, "R10 clear reads 0");

    // R11 unmapped
    wr(10'h108, 8'hFF);
    wr(10'h3FF, 8'hFF);
    chk("R11 pin_oe unchanged", pin_oe, 8'h0F);
    chk("R11 pin_out unchanged", pin_out, 8'h0A);
    chk("R11 cfg unchanged", irq_sense, 8'h11);
    rd(10'h108, 8'h00, "R11 unmapped read 420");
    rd(10'h3FF, 8'h00, "R11 unmapped read FFC");

    // R12 read data holds over idle and writes
    rd(10'h104, 8'h0F, "R12 enable read");
    idle(3);
    wr(10'h104, 8'h0F);
    chk("R12 rdata held", bus_rdata, last_rd);

    idle(3);
    if (q_exp.size() != 0) begin
      checks++; failures++;
      $display("FAIL R12 pending reads actual=%0d expected=0", q_exp.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule